// File: doc/BRIEF.md
# USB Serial Receive Path

This block turns a stream of sampled USB line bits into bytes on a UTMI-style receive interface. Each serial tick delivers one sampled data bit together with the raw D+ and D- levels and a one-cycle bit strobe. The sampled bit goes through an NRZI decoder, then a destuffer that removes the zero inserted after six ones, and then a shift register that packs the destuffed bits into bytes, least significant bit first.

A packet starts when the decoded stream shows the SYNC pattern: seven zeros followed by a one. Receive-active then rises and stays high while the packet is received. It falls on an SE0 end-of-packet tick, or when a stuffing violation is seen, which also pulses receive-error. The bus line state is reported every clock as {D-, D+}. The 8:1 deserializer, clock recovery and squelch sit outside this block.

Top module: `usb_rx_path`

## Requirements
- R1: NRZI decode yields 1 when a strobed sample equals the previous strobed level and 0 when it differs. The previous level is J (1) after reset, and every SE0 tick ({D-,D+} = 00 with the strobe) sets it back to J.
- R2: While no packet is open, receive-active rises in the cycle after the strobe that completes the decoded sequence 0,0,0,0,0,0,0,1 (seven zeros, then a one). No shorter or different sequence opens a packet. The hunt history is all ones after reset and after every SE0 tick.
- R3: Inside a packet, the first destuffed bit after SYNC becomes bit 0 of the byte. In the cycle after the strobe that delivers the eighth bit, receive-valid is high for exactly one cycle and the data output holds the byte. The data output keeps that byte until the next byte completes.
- R4: Inside a packet, a decoded 0 that follows six consecutive decoded 1s is dropped and is not counted as data. The run count starts at zero when the packet opens, so the final 1 of SYNC is not part of a run, and any data 0 clears the run.
- R5: A decoded 1 in the position of a stuffed bit ends the packet. In the next cycle receive-error is high for one cycle and receive-active is low. After that, strobed bits are ignored, SYNC included, until an SE0 tick.
- R6: An SE0 tick inside a packet drops receive-active in the next cycle. Any partly assembled byte is discarded and no receive-valid follows.
- R7: The line-state output equals {D-, D+} as sampled at the previous clock edge, with 00 = SE0, 01 = J, 10 = K and 11 = SE1, whether or not the strobe is high.
- R8: Asserting the asynchronous reset at once forces receive-active, receive-valid, receive-error and line state to 0 and returns the control to SYNC hunt.
- R9: Clock cycles without the bit strobe have no effect on decoding, destuffing or packet state, even if the line levels read as SE0 in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parallel-domain clock |
| arst_i | input | 1 | Asynchronous reset, active high |
| bit_vld_i | input | 1 | Strobe: one serial bit is present this cycle |
| rx_bit_i | input | 1 | Sampled differential bit (1 = J level) |
| line_dp_i | input | 1 | Raw D+ level |
| line_dn_i | input | 1 | Raw D- level |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Byte on rx_data_o is new this cycle |
| rx_active_o | output | 1 | A packet is being received |
| rx_error_o | output | 1 | One-cycle pulse on a bit-stuffing violation |
| line_state_o | output | 2 | {D-, D+} line state |

## Verification
On every cycle, the assertions check the following:
- the destuffer run count never passes six;
- receive-valid is a single-cycle pulse that occurs only inside a packet;
- an error pulse coincides with the fall of receive-active;
- an SE0 tick resets the NRZI reference level and closes a packet;
- the line state follows the pins with one cycle of delay.

Some behaviours can only be shown by the bench scenarios:
- that bytes come out with the right values across NRZI transitions, inserted stuff bits and idle gaps full of SE0 noise;
- that near-miss SYNC patterns do not open a packet;
- that a SYNC seen after a stuffing error is ignored until an SE0 tick.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_DATA  = 2'd1,
        ST_DRAIN = 2'd2
    } rx_state_e;

    localparam logic [1:0] LS_SE0 = 2'b00;
    localparam logic [1:0] LS_J   = 2'b01;
    localparam logic [1:0] LS_K   = 2'b10;
    localparam logic [1:0] LS_SE1 = 2'b11;

endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi (
    input  logic clk_i,
    input  logic arst_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic se0_i,
    output logic dec_vld_o,
    output logic dec_bit_o
);

    typedef struct packed {
        logic prev;
    } nrzi_st_t;

    nrzi_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_vld_i) begin
            st_d.prev = se0_i ? 1'b1 : bit_i;
        end
        dec_vld_o = bit_vld_i & ~se0_i;
        dec_bit_o = (bit_i == st_q.prev);
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            st_q <= '{prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    AST_SE0_RELOAD: assert property (@(posedge clk_i) disable iff (arst_i)
        (bit_vld_i && se0_i) |=> st_q.prev); // R1

    AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (arst_i)
        !bit_vld_i |=> $stable(st_q.prev)); // R9

endmodule

// File: rtl/usb_rx_destuff.sv
module usb_rx_destuff #(
    parameter int RUN_MAX = 6
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic en_i,
    input  logic vld_i,
    input  logic bit_i,
    output logic vld_o,
    output logic bit_o,
    output logic err_o
);

    localparam int CNT_W = $clog2(RUN_MAX + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } ds_st_t;

    ds_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        vld_o = 1'b0;
        err_o = 1'b0;
        bit_o = bit_i;
        if (!en_i) begin
            st_d.run = '0;
        end else if (vld_i) begin
            if (st_q.run == RUN_LAST) begin
                st_d.run = '0;
                err_o    = bit_i;
            end else begin
                vld_o    = 1'b1;
                st_d.run = bit_i ? st_q.run + 1'b1 : '0;
            end
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            st_q <= '{run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (arst_i)
        st_q.run <= RUN_LAST); // R4

    AST_ERR_CLEARS: assert property (@(posedge clk_i) disable iff (arst_i)
        err_o |=> (st_q.run == '0)); // R5

    AST_PASS_ONLY_IN_PKT: assert property (@(posedge clk_i) disable iff (arst_i)
        vld_o |-> (en_i && vld_i)); // R4

endmodule

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl
    import usb_rx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SYNC_W = 8
) (
    input  logic              clk_i,
    input  logic              arst_i,
    input  logic              tick_i,
    input  logic              se0_i,
    input  logic              dec_vld_i,
    input  logic              dec_bit_i,
    input  logic              ds_vld_i,
    input  logic              ds_bit_i,
    input  logic              stuff_err_i,
    output logic              active_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              error_o
);

    localparam int BCNT_W = $clog2(BYTE_W);
    localparam logic [BCNT_W-1:0] BIT_LAST = BCNT_W'(BYTE_W - 1);
    localparam logic [SYNC_W-1:0] SYNC_WORD = {1'b1, {(SYNC_W-1){1'b0}}};

    typedef struct packed {
        rx_state_e          st;
        logic [SYNC_W-1:0]  hunt;
        logic [BYTE_W-1:0]  shreg;
        logic [BCNT_W-1:0]  bcnt;
        logic [BYTE_W-1:0]  data;
        logic               valid;
        logic               error;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [SYNC_W-1:0] hunt_nx;
    logic [BYTE_W-1:0] shreg_nx;
    logic              eop_tick;

    always_comb begin
        st_d     = st_q;
        st_d.valid = 1'b0;
        st_d.error = 1'b0;
        eop_tick = tick_i & se0_i;
        hunt_nx  = {dec_bit_i, st_q.hunt[SYNC_W-1:1]};
        shreg_nx = {ds_bit_i, st_q.shreg[BYTE_W-1:1]};
        unique case (st_q.st)
            ST_HUNT: begin
                if (eop_tick) begin
                    st_d.hunt = '1;
                end else if (dec_vld_i) begin
                    if (hunt_nx == SYNC_WORD) begin
                        st_d.st   = ST_DATA;
                        st_d.hunt = '1;
                        st_d.bcnt = '0;
                    end else begin
                        st_d.hunt = hunt_nx;
                    end
                end
            end
            ST_DATA: begin
                if (eop_tick) begin
                    st_d.st   = ST_HUNT;
                    st_d.bcnt = '0;
                end else if (stuff_err_i) begin
                    st_d.st    = ST_DRAIN;
                    st_d.error = 1'b1;
                    st_d.bcnt  = '0;
                end else if (ds_vld_i) begin
                    st_d.shreg = shreg_nx;
                    if (st_q.bcnt == BIT_LAST) begin
                        st_d.data  = shreg_nx;
                        st_d.valid = 1'b1;
                        st_d.bcnt  = '0;
                    end else begin
                        st_d.bcnt = st_q.bcnt + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (eop_tick) begin
                    st_d.st = ST_HUNT;
                end
            end
            default: begin
                st_d.st = ST_HUNT;
            end
        endcase
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            st_q <= '{st: ST_HUNT, hunt: '1, shreg: '0, bcnt: '0,
                      data: '0, valid: 1'b0, error: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.st == ST_DATA);
    assign data_o   = st_q.data;
    assign valid_o  = st_q.valid;
    assign error_o  = st_q.error;

    AST_SYNC_START: assert property (@(posedge clk_i) disable iff (arst_i)
        (st_q.st == ST_DATA && $past(st_q.st == ST_HUNT)) |-> $past(dec_vld_i && dec_bit_i)); // R2

    AST_VALID_IN_PKT: assert property (@(posedge clk_i) disable iff (arst_i)
        valid_o |-> active_o); // R3

    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (arst_i)
        valid_o |=> !valid_o); // R3

    AST_ERR_ENDS_PKT: assert property (@(posedge clk_i) disable iff (arst_i)
        error_o |-> (!active_o && $past(active_o))); // R5

    AST_EOP_CLOSE: assert property (@(posedge clk_i) disable iff (arst_i)
        (active_o && tick_i && se0_i) |=> !active_o); // R6

    AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (arst_i)
        (st_q.st == ST_DRAIN && !(tick_i && se0_i)) |=> (st_q.st == ST_DRAIN)); // R5

endmodule

// File: rtl/usb_rx_path.sv
module usb_rx_path
    import usb_rx_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int SYNC_W  = 8,
    parameter int RUN_MAX = 6
) (
    input  logic              clk_i,
    input  logic              arst_i,
    input  logic              bit_vld_i,
    input  logic              rx_bit_i,
    input  logic              line_dp_i,
    input  logic              line_dn_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_active_o,
    output logic              rx_error_o,
    output logic [1:0]        line_state_o
);

    logic       se0;
    logic       dec_vld, dec_bit;
    logic       ds_vld, ds_bit, ds_err;
    logic       pkt_open;
    logic [1:0] ls_d, ls_q;
    logic       armed_q;

    assign se0 = ~line_dp_i & ~line_dn_i;

    usb_rx_nrzi u_nrzi (
        .clk_i     (clk_i),
        .arst_i    (arst_i),
        .bit_vld_i (bit_vld_i),
        .bit_i     (rx_bit_i),
        .se0_i     (se0),
        .dec_vld_o (dec_vld),
        .dec_bit_o (dec_bit)
    );

    usb_rx_destuff #(.RUN_MAX(RUN_MAX)) u_destuff (
        .clk_i  (clk_i),
        .arst_i (arst_i),
        .en_i   (pkt_open),
        .vld_i  (dec_vld),
        .bit_i  (dec_bit),
        .vld_o  (ds_vld),
        .bit_o  (ds_bit),
        .err_o  (ds_err)
    );

    usb_rx_ctrl #(.BYTE_W(BYTE_W), .SYNC_W(SYNC_W)) u_ctrl (
        .clk_i       (clk_i),
        .arst_i      (arst_i),
        .tick_i      (bit_vld_i),
        .se0_i       (se0),
        .dec_vld_i   (dec_vld),
        .dec_bit_i   (dec_bit),
        .ds_vld_i    (ds_vld),
        .ds_bit_i    (ds_bit),
        .stuff_err_i (ds_err),
        .active_o    (pkt_open),
        .data_o      (rx_data_o),
        .valid_o     (rx_valid_o),
        .error_o     (rx_error_o)
    );

    always_comb begin
        ls_d = {line_dn_i, line_dp_i};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            ls_q    <= LS_SE0;
            armed_q <= 1'b0;
        end else begin
            ls_q    <= ls_d;
            armed_q <= 1'b1;
        end
    end

    assign line_state_o = ls_q;
    assign rx_active_o  = pkt_open;

    AST_LINE_FOLLOW: assert property (@(posedge clk_i) disable iff (arst_i)
        armed_q |-> (line_state_o == $past({line_dn_i, line_dp_i}))); // R7

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        arst_i |-> (!rx_active_o && !rx_valid_o && !rx_error_o)); // R8

endmodule

// File: tb/usb_rx_path_tb_top.sv
module usb_rx_path_tb_top;

    logic       clk = 1'b0;
    logic       arst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       rx_bit = 1'b1;
    logic       dp = 1'b1;
    logic       dn = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_active, rx_error;
    logic [1:0] line_state;

    int checks = 0;
    int errors = 0;
    int gap = 0;
    int run = 0;
    logic level = 1'b1;
    logic [7:0] rcv [0:63];
    int rcv_n = 0;
    int err_n = 0;

    // entries: {gap cycles, byte3, byte2, byte1, byte0}; byte0 is sent first
    localparam logic [39:0] VEC [0:4] = '{
        {8'd0, 32'h04_03_02_01},
        {8'd0, 32'hFF_FF_FF_FF},
        {8'd2, 32'h00_00_00_00},
        {8'd1, 32'hA5_3F_7E_C0},
        {8'd3, 32'h80_FE_FC_01}
    };

    always #4 clk = ~clk;

    usb_rx_path dut_i (
        .clk_i        (clk),
        .arst_i       (arst),
        .bit_vld_i    (bit_vld),
        .rx_bit_i     (rx_bit),
        .line_dp_i    (dp),
        .line_dn_i    (dn),
        .rx_data_o    (rx_data),
        .rx_valid_o   (rx_valid),
        .rx_active_o  (rx_active),
        .rx_error_o   (rx_error),
        .line_state_o (line_state)
    );

    always @(negedge clk) begin
        if (rx_valid && rcv_n < 64) begin
            rcv[rcv_n] = rx_data;
            rcv_n = rcv_n + 1;
        end
        if (rx_error) err_n = err_n + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic b, input logic p, input logic n);
        @(negedge clk);
        bit_vld = 1'b1; rx_bit = b; dp = p; dn = n;
        @(negedge clk);
        bit_vld = 1'b0;
        for (int g = 0; g < gap; g++) begin
            rx_bit = ~rx_bit; dp = 1'b0; dn = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic send_level(input logic l);
        tick(l, l, ~l);
    endtask

    task automatic send_dec(input logic b);
        if (!b) level = ~level;
        send_level(level);
    endtask

    task automatic send_bit(input logic b);
        send_dec(b);
        run = b ? run + 1 : 0;
        if (run == 6) begin
            send_dec(1'b0);
            run = 0;
        end
    endtask

    task automatic send_sync();
        for (int i = 0; i < 7; i++) send_dec(1'b0);
        send_dec(1'b1);
        run = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_eop();
        tick(1'b0, 1'b0, 1'b0);
        level = 1'b1;
        send_level(1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        #20;
        chk("R8 reset active", rx_active, 0);
        chk("R8 reset valid", rx_valid, 0);
        chk("R8 reset error", rx_error, 0);
        chk("R8 reset line state", line_state, 2'b00);
        @(negedge clk);
        arst = 1'b0;
        repeat (2) @(negedge clk);

        // table walk: R1 R3 R4 (R9 when gap > 0)
        for (int v = 0; v < 5; v++) begin
            gap = int'(VEC[v][39:32]);
            base = rcv_n;
            send_level(1'b1);
            send_level(1'b1);
            send_sync();
            for (int k = 0; k < 4; k++) send_byte(VEC[v][8*k +: 8]);
            send_eop();
            gap = 0;
            repeat (3) @(negedge clk);
            chk($sformatf("R3 vec%0d byte count", v), rcv_n - base, 4);
            for (int k = 0; k < 4; k++)
                chk($sformatf("R1/R3/R4/R9 vec%0d byte%0d", v, k),
                    rcv[base + k], VEC[v][8*k +: 8]);
            chk($sformatf("R4 vec%0d no stuff error", v), err_n, 0);
            chk($sformatf("R6 vec%0d closed", v), rx_active, 0);
        end

        // R2: near-miss then exact SYNC
        send_level(1'b1);
        for (int i = 0; i < 6; i++) send_dec(1'b0);
        send_dec(1'b1);
        chk("R2 six zeros then one stays idle", rx_active, 0);
        for (int i = 0; i < 7; i++) send_dec(1'b0);
        chk("R2 not open before final one", rx_active, 0);
        send_dec(1'b1);
        chk("R2 open right after sync", rx_active, 1);
        send_eop();

        // R1: SE0 reloads NRZI reference to J
        tick(1'b0, 1'b0, 1'b0);
        level = 1'b1;
        send_sync();
        chk("R1 sync decoded after SE0 reload", rx_active, 1);
        send_eop();

        // R5: stuffing violation
        send_sync();
        for (int i = 0; i < 6; i++) send_dec(1'b1);
        send_dec(1'b1);
        chk("R5 error pulse", rx_error, 1);
        chk("R5 active dropped", rx_active, 0);
        @(negedge clk);
        chk("R5 error one cycle", rx_error, 0);
        send_sync();
        chk("R5 sync ignored in drain", rx_active, 0);
        send_eop();
        base = rcv_n;
        send_sync();
        chk("R5 reopen after SE0", rx_active, 1);
        send_byte(8'h5A);
        send_eop();
        repeat (2) @(negedge clk);
        chk("R5 byte after recovery", rcv[base], 8'h5A);

        // R6: SE0 mid-byte
        base = rcv_n;
        send_sync();
        for (int i = 0; i < 4; i++) send_bit(i[0]);
        tick(1'b0, 1'b0, 1'b0);
        chk("R6 active low after SE0", rx_active, 0);
        level = 1'b1;
        send_level(1'b1);
        repeat (3) @(negedge clk);
        chk("R6 partial byte dropped", rcv_n - base, 0);

        // R9: SE0 levels without strobe do nothing
        send_sync();
        dp = 1'b0; dn = 1'b0; rx_bit = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 packet survives unstrobed SE0", rx_active, 1);
        base = rcv_n;
        send_byte(8'hC3);
        send_eop();
        repeat (2) @(negedge clk);
        chk("R9 byte intact", rcv[base], 8'hC3);

        // R7: line state follows pins, no strobe
        for (int c = 0; c < 4; c++) begin
            dp = c[0]; dn = c[1];
            @(negedge clk);
            chk($sformatf("R7 line state %0d", c), line_state, c[1:0]);
        end
        dp = 1'b1; dn = 1'b0;
        @(negedge clk);

        // R8: asynchronous reset mid-packet
        send_sync();
        chk("R8 packet open", rx_active, 1);
        #1 arst = 1'b1;
        #1;
        chk("R8 async clears active", rx_active, 0);
        chk("R8 async clears line state", line_state, 2'b00);
        @(negedge clk);
        arst = 1'b0;
        level = 1'b1;
        repeat (2) @(negedge clk);
        send_sync();
        chk("R8 hunt works after reset", rx_active, 1);
        send_eop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule